// File: doc/BRIEF.md
# Dual-Clock FIFO with Fall-Through Mode

This block is a first-in first-out buffer that sits between two unrelated clock domains. The producer writes one word per write-clock edge while its active-low write enable is low. The consumer reads one word per read-clock edge while its active-low read enable is low. The storage is a dual-port array of `2**ADDR_W` words. Each side keeps its own binary pointer. The pointers cross to the other side as Gray code through a chain of synchroniser flops. The full condition is formed in the write domain and the empty condition in the read domain.

A mode bit is captured while master reset is held. In standard mode a word leaves the array only when the consumer reads it. The two flag outputs then mean "full" and "empty". In fall-through mode the oldest word is moved to the output register without a read, and the flags mean "space available" and "word valid". Partial reset empties the buffer and keeps the mode. A rewind request sends the read pointer back to location zero so that data written since the last reset can be read again. An active-low output enable puts the data outputs in high impedance.

Top module: `dcf_fifo_ft`

## Requirements
- R1: A word is stored on each rising `wr_clk` edge with `wr_en_n` low and the buffer not full. A word is taken on each rising `rd_clk` edge with `rd_en_n` low and a word available. Words leave in the order they were stored.
- R2: In standard mode (mode bit 0), `wr_flag` is 1 when the buffer holds `2**ADDR_W` words and `rd_flag` is 1 when it holds none. `rd_data` changes only on an accepted read.
- R3: In fall-through mode (mode bit 1), a word written into an empty buffer appears on `rd_data`, with `rd_flag` = 1, on the third rising `rd_clk` edge after the write edge, with no read. Each later word is presented only after a read with `rd_en_n` low.
- R4: `mode_sel` is captured on every clock edge that samples `mrst_n` low, in each domain. 0 selects standard mode and 1 selects fall-through mode. The value holds until the next master reset. In fall-through mode `wr_flag` = 1 means space is available and `rd_flag` = 1 means a valid word is on `rd_data`.
- R5: Master reset (`mrst_n` low, sampled synchronously in both domains) clears both pointers and the output register. Afterwards `rd_data` = 0. In standard mode `rd_flag` = 1 and `wr_flag` = 0. In fall-through mode `rd_flag` = 0 and `wr_flag` = 1.
- R6: Partial reset (`prst_n` low) clears both pointers and the output register the same way, and leaves the captured mode unchanged.
- R7: `rewind_n` low on a rising `rd_clk` edge sets the read pointer to zero and leaves the write pointer alone. In standard mode `rd_flag` reads 1 for the following cycle. In fall-through mode `rd_flag` reads 0 for one cycle, and then the word at location zero is presented. Rewind is valid only while at most `2**ADDR_W` words have been written since the last reset.
- R8: When rewind and read fall on the same `rd_clk` edge, the rewind wins, the read is dropped and `rd_data` keeps its value.
- R9: A write while full is ignored: the write pointer does not move and the stored words are unchanged. A read while empty is ignored: the read pointer does not move and `rd_data` keeps its value.
- R10: With `oe_n` = 1 every bit of `rd_data` is high impedance. With `oe_n` = 0 it drives the output register.
- R11: The write pointer reaches the read domain through two synchroniser flops. In standard mode, after a write into an empty buffer, `rd_flag` is still 1 after the first following `rd_clk` edge and is 0 after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| mrst_n | input | 1 | Master reset, active low, sampled by both clocks |
| prst_n | input | 1 | Partial reset, active low, keeps the mode |
| mode_sel | input | 1 | Mode captured during master reset: 0 standard, 1 fall-through |
| wr_en_n | input | 1 | Write enable, active low |
| wr_data | input | DATA_W | Word to store |
| wr_flag | output | 1 | Standard: full; fall-through: space available |
| rd_en_n | input | 1 | Read enable, active low |
| rewind_n | input | 1 | Rewind the read pointer to zero, active low |
| oe_n | input | 1 | Output enable, active low |
| rd_data | output | DATA_W | Output register, high impedance when disabled |
| rd_flag | output | 1 | Standard: empty; fall-through: word valid |

## Verification
A rewind and a read can be requested on the same read-clock edge. The bench provokes this case in standard mode after two words have been read out of three. It raises `rd_en_n` low and `rewind_n` low together for one edge. The outcome is judged at the ports: `rd_data` must still show the second word and `rd_flag` must read empty for that cycle. After that the flag clears, and the next three reads must return the first, second and third words again. In fall-through mode a consuming read and the refill of the output register share an edge, and the bench checks that the next word is shown right after that edge.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

  typedef enum logic {
    MODE_STD = 1'b0,
    MODE_FT  = 1'b1
  } fifo_mode_e;

  // Binary to reflected Gray code, on a zero-extended 32-bit value.
  function automatic logic [31:0] to_gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  // Gray back to binary by prefix XOR from the top bit down.
  function automatic logic [31:0] from_gray(input logic [31:0] g);
    logic [31:0] r;
    r = g;
    r = r ^ (r >> 1);
    r = r ^ (r >> 2);
    r = r ^ (r >> 4);
    r = r ^ (r >> 8);
    r = r ^ (r >> 16);
    return r;
  endfunction

  // Words held, given pointers that carry one wrap bit above the address.
  function automatic logic [31:0] words_held(input logic [31:0] wp,
                                             input logic [31:0] rp,
                                             input int          ptr_w);
    logic [31:0] mask;
    mask = (32'd1 << ptr_w) - 32'd1;
    return (wp - rp) & mask;
  endfunction

endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         clr,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (clr) stg[0] <= '0;
    else     stg[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (clr) stg[i] <= '0;
      else     stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/dcf_wr_ctl.sv
module dcf_wr_ctl
  import dcf_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int STAGES = 2
) (
  input  logic              wr_clk,
  input  logic              mrst_n,
  input  logic              prst_n,
  input  logic              mode_sel,
  input  logic              wr_en_n,
  input  logic [ADDR_W:0]   rptr_gray_x,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              wr_push,
  output logic              full,
  output logic [ADDR_W:0]   wptr_bin,
  output logic [ADDR_W:0]   wptr_gray,
  output logic [ADDR_W:0]   rptr_seen,
  output fifo_mode_e        mode_q,
  output logic              wr_flag
);

  localparam int PTR_W = ADDR_W + 1;

  logic             clr;
  logic [PTR_W-1:0] rsync_gray;
  logic [PTR_W-1:0] wptr_nxt;
  logic [31:0]      rptr_wide;
  logic [31:0]      gray_nxt;

  assign clr = !mrst_n || !prst_n;

  dcf_sync #(.W(PTR_W), .STAGES(STAGES)) u_rsync (
    .clk (wr_clk),
    .clr (clr),
    .d   (rptr_gray_x),
    .q   (rsync_gray)
  );

  assign rptr_wide = from_gray(32'(rsync_gray));
  assign rptr_seen = rptr_wide[PTR_W-1:0];

  // Full: same address, opposite wrap bit.
  assign full = (wptr_bin[ADDR_W] != rptr_seen[ADDR_W]) &&
                (wptr_bin[ADDR_W-1:0] == rptr_seen[ADDR_W-1:0]);

  assign wr_push  = !wr_en_n && !full;
  assign wptr_nxt = wptr_bin + PTR_W'(1);
  assign gray_nxt = to_gray(32'(wptr_nxt));
  assign wr_addr  = wptr_bin[ADDR_W-1:0];

  always_ff @(posedge wr_clk) begin
    if (clr) begin
      wptr_bin  <= '0;
      wptr_gray <= '0;
    end else if (wr_push) begin
      wptr_bin  <= wptr_nxt;
      wptr_gray <= gray_nxt[PTR_W-1:0];
    end
  end

  always_ff @(posedge wr_clk) begin
    if (!mrst_n) mode_q <= fifo_mode_e'(mode_sel);
  end

  assign wr_flag = (mode_q == MODE_FT) ? !full : full;

endmodule

// File: rtl/dcf_rd_ctl.sv
module dcf_rd_ctl
  import dcf_pkg::*;
#(
  parameter int DATA_W = 18,
  parameter int ADDR_W = 4,
  parameter int STAGES = 2
) (
  input  logic              rd_clk,
  input  logic              mrst_n,
  input  logic              prst_n,
  input  logic              mode_sel,
  input  logic              rd_en_n,
  input  logic              rewind_n,
  input  logic [ADDR_W:0]   wptr_gray_x,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              rd_load,
  output logic [ADDR_W:0]   rptr_bin,
  output logic [ADDR_W:0]   rptr_gray,
  output logic [DATA_W-1:0] q_reg,
  output fifo_mode_e        mode_q,
  output logic              rd_flag
);

  localparam int PTR_W = ADDR_W + 1;

  logic             clr;
  logic [PTR_W-1:0] wsync_gray;
  logic [PTR_W-1:0] wptr_seen;
  logic [PTR_W-1:0] rptr_nxt;
  logic [31:0]      wptr_wide;
  logic [31:0]      gray_nxt;
  logic             ft;
  logic             mem_empty;
  logic             valid_q;
  logic             blip_q;
  logic             std_take;
  logic             ft_take;
  logic             ft_fill;

  assign clr = !mrst_n || !prst_n;

  dcf_sync #(.W(PTR_W), .STAGES(STAGES)) u_wsync (
    .clk (rd_clk),
    .clr (clr),
    .d   (wptr_gray_x),
    .q   (wsync_gray)
  );

  assign wptr_wide = from_gray(32'(wsync_gray));
  assign wptr_seen = wptr_wide[PTR_W-1:0];

  assign ft        = (mode_q == MODE_FT);
  assign mem_empty = (rptr_bin == wptr_seen);

  // Standard: a read moves a word only when the flag shows data.
  assign std_take = !ft && !rd_en_n && !mem_empty && !blip_q;
  // Fall-through: a read consumes the presented word; refill when free.
  assign ft_take  = ft && valid_q && !rd_en_n;
  assign ft_fill  = ft && !mem_empty && (!valid_q || ft_take);
  assign rd_load  = std_take || ft_fill;

  assign rptr_nxt = rptr_bin + PTR_W'(1);
  assign gray_nxt = to_gray(32'(rptr_nxt));
  assign rd_addr  = rptr_bin[ADDR_W-1:0];

  always_ff @(posedge rd_clk) begin
    if (clr) begin
      rptr_bin  <= '0;
      rptr_gray <= '0;
      q_reg     <= '0;
      valid_q   <= 1'b0;
      blip_q    <= 1'b0;
    end else if (!rewind_n) begin
      rptr_bin  <= '0;
      rptr_gray <= '0;
      valid_q   <= 1'b0;
      blip_q    <= 1'b1;
    end else begin
      blip_q <= 1'b0;
      if (rd_load) begin
        q_reg     <= mem_rdata;
        rptr_bin  <= rptr_nxt;
        rptr_gray <= gray_nxt[PTR_W-1:0];
      end
      if (ft_fill)      valid_q <= 1'b1;
      else if (ft_take) valid_q <= 1'b0;
    end
  end

  always_ff @(posedge rd_clk) begin
    if (!mrst_n) mode_q <= fifo_mode_e'(mode_sel);
  end

  assign rd_flag = ft ? valid_q : (mem_empty || blip_q);

endmodule

// File: rtl/dcf_fifo_ft.sv
module dcf_fifo_ft
  import dcf_pkg::*;
#(
  parameter int DATA_W = 18,
  parameter int ADDR_W = 4,
  parameter int STAGES = 2
) (
  input  logic              wr_clk,
  input  logic              rd_clk,
  input  logic              mrst_n,
  input  logic              prst_n,
  input  logic              mode_sel,
  input  logic              wr_en_n,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_flag,
  input  logic              rd_en_n,
  input  logic              rewind_n,
  input  logic              oe_n,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_flag
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int PTR_W = ADDR_W + 1;

  logic [DATA_W-1:0] mem [DEPTH];

  logic [ADDR_W-1:0] wr_addr;
  logic [ADDR_W-1:0] rd_addr;
  logic              wr_push;
  logic              full_w;
  logic [PTR_W-1:0]  wptr_bin;
  logic [PTR_W-1:0]  wptr_gray;
  logic [PTR_W-1:0]  rptr_seen_w;
  logic [PTR_W-1:0]  rptr_bin;
  logic [PTR_W-1:0]  rptr_gray;
  logic              rd_load;
  logic [DATA_W-1:0] q_reg;
  fifo_mode_e        mode_w;
  fifo_mode_e        mode_r;
  logic [31:0]       fill_wide;
  logic [PTR_W-1:0]  fill_w;

  dcf_wr_ctl #(.ADDR_W(ADDR_W), .STAGES(STAGES)) u_wr (
    .wr_clk      (wr_clk),
    .mrst_n      (mrst_n),
    .prst_n      (prst_n),
    .mode_sel    (mode_sel),
    .wr_en_n     (wr_en_n),
    .rptr_gray_x (rptr_gray),
    .wr_addr     (wr_addr),
    .wr_push     (wr_push),
    .full        (full_w),
    .wptr_bin    (wptr_bin),
    .wptr_gray   (wptr_gray),
    .rptr_seen   (rptr_seen_w),
    .mode_q      (mode_w),
    .wr_flag     (wr_flag)
  );

  dcf_rd_ctl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .STAGES(STAGES)) u_rd (
    .rd_clk      (rd_clk),
    .mrst_n      (mrst_n),
    .prst_n      (prst_n),
    .mode_sel    (mode_sel),
    .rd_en_n     (rd_en_n),
    .rewind_n    (rewind_n),
    .wptr_gray_x (wptr_gray),
    .mem_rdata   (mem[rd_addr]),
    .rd_addr     (rd_addr),
    .rd_load     (rd_load),
    .rptr_bin    (rptr_bin),
    .rptr_gray   (rptr_gray),
    .q_reg       (q_reg),
    .mode_q      (mode_r),
    .rd_flag     (rd_flag)
  );

  always_ff @(posedge wr_clk) begin
    if (wr_push) mem[wr_addr] <= wr_data;
  end

  // Occupancy as the write side sees it, for the checker.
  assign fill_wide = words_held(32'(wptr_bin), 32'(rptr_seen_w), PTR_W);
  assign fill_w    = fill_wide[PTR_W-1:0];

  assign rd_data = oe_n ? {DATA_W{1'bz}} : q_reg;

endmodule

module dcf_fifo_ft_chk
  import dcf_pkg::*;
#(
  parameter int DATA_W = 18,
  parameter int ADDR_W = 4
) (
  input logic              wr_clk,
  input logic              rd_clk,
  input logic              mrst_n,
  input logic              prst_n,
  input logic              wr_en_n,
  input logic              rd_en_n,
  input logic              rewind_n,
  input logic              full_w,
  input logic [ADDR_W:0]   wptr_bin,
  input logic [ADDR_W:0]   rptr_bin,
  input logic [ADDR_W:0]   fill_w,
  input logic [DATA_W-1:0] q_reg,
  input logic              rd_flag,
  input fifo_mode_e        mode_r
);

  localparam int DEPTH = 1 << ADDR_W;

  // R9
  no_overflow_chk: assert property (@(posedge wr_clk) disable iff (!mrst_n || !prst_n)
    (full_w && !wr_en_n) |=> $stable(wptr_bin));

  // R9
  no_underflow_chk: assert property (@(posedge rd_clk) disable iff (!mrst_n || !prst_n)
    (mode_r == MODE_STD && rd_flag && rewind_n) |=> $stable(rptr_bin));

  // R7
  rewind_ptr_chk: assert property (@(posedge rd_clk) disable iff (!mrst_n || !prst_n)
    !rewind_n |=> (rptr_bin == '0));

  // R8
  rewind_wins_chk: assert property (@(posedge rd_clk) disable iff (!mrst_n || !prst_n)
    (!rewind_n && !rd_en_n) |=> $stable(q_reg));

  // R4
  mode_hold_chk: assert property (@(posedge rd_clk) disable iff (!mrst_n)
    mrst_n |=> $stable(mode_r));

  // R3
  ft_hold_chk: assert property (@(posedge rd_clk) disable iff (!mrst_n || !prst_n)
    (mode_r == MODE_FT && rd_flag && rd_en_n && rewind_n) |=> (rd_flag && $stable(q_reg)));

  // R2
  std_hold_chk: assert property (@(posedge rd_clk) disable iff (!mrst_n || !prst_n)
    (mode_r == MODE_STD && rd_en_n) |=> $stable(q_reg));

  // R1
  fill_bound_chk: assert property (@(posedge wr_clk) disable iff (!mrst_n || !prst_n)
    fill_w <= (ADDR_W+1)'(DEPTH));

endmodule

bind dcf_fifo_ft dcf_fifo_ft_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .wr_clk   (wr_clk),
  .rd_clk   (rd_clk),
  .mrst_n   (mrst_n),
  .prst_n   (prst_n),
  .wr_en_n  (wr_en_n),
  .rd_en_n  (rd_en_n),
  .rewind_n (rewind_n),
  .full_w   (full_w),
  .wptr_bin (wptr_bin),
  .rptr_bin (rptr_bin),
  .fill_w   (fill_w),
  .q_reg    (q_reg),
  .rd_flag  (rd_flag),
  .mode_r   (mode_r)
);

// File: tb/dcf_fifo_ft_tb.sv
module dcf_fifo_ft_tb;

  localparam int DW    = 18;
  localparam int AW    = 4;
  localparam int DEPTH = 1 << AW;

  logic          wr_clk = 1'b0;
  logic          rd_clk = 1'b0;
  logic          mrst_n = 1'b0;
  logic          prst_n = 1'b1;
  logic          mode_sel = 1'b0;
  logic          wr_en_n = 1'b1;
  logic [DW-1:0] wr_data = '0;
  logic          wr_flag;
  logic          rd_en_n = 1'b1;
  logic          rewind_n = 1'b1;
  logic          oe_n = 1'b0;
  logic [DW-1:0] rd_data;
  logic          rd_flag;

  int n_chk  = 0;
  int n_fail = 0;

  dcf_fifo_ft #(.DATA_W(DW), .ADDR_W(AW)) u_dut (
    .wr_clk   (wr_clk),
    .rd_clk   (rd_clk),
    .mrst_n   (mrst_n),
    .prst_n   (prst_n),
    .mode_sel (mode_sel),
    .wr_en_n  (wr_en_n),
    .wr_data  (wr_data),
    .wr_flag  (wr_flag),
    .rd_en_n  (rd_en_n),
    .rewind_n (rewind_n),
    .oe_n     (oe_n),
    .rd_data  (rd_data),
    .rd_flag  (rd_flag)
  );

  // 125 MHz on both sides; read edges trail write edges by 1 ns.
  initial forever #4 wr_clk = ~wr_clk;
  initial begin
    #1;
    forever #4 rd_clk = ~rd_clk;
  end

  // {do_write, write word, do_read, expected rd_data after the read}
  localparam logic [37:0] VEC [6] = '{
    {1'b1, 18'h1A5, 1'b1, 18'h1A5},
    {1'b1, 18'h2B6, 1'b0, 18'h1A5},
    {1'b1, 18'h3C7, 1'b1, 18'h2B6},
    {1'b0, 18'h000, 1'b1, 18'h3C7},
    {1'b0, 18'h000, 1'b1, 18'h3C7},
    {1'b1, 18'h0D8, 1'b1, 18'h0D8}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic wr_word(input logic [DW-1:0] d);
    @(negedge wr_clk);
    wr_en_n = 1'b0;
    wr_data = d;
    @(posedge wr_clk);
    #2;
    wr_en_n = 1'b1;
  endtask

  task automatic rd_step(input logic ren, input logic rew);
    @(negedge rd_clk);
    rd_en_n  = ~ren;
    rewind_n = ~rew;
    @(posedge rd_clk);
    #1;
    rd_en_n  = 1'b1;
    rewind_n = 1'b1;
  endtask

  task automatic master_reset(input logic m);
    @(negedge wr_clk);
    mrst_n   = 1'b0;
    mode_sel = m;
    repeat (4) @(negedge wr_clk);
    mrst_n = 1'b1;
    repeat (2) @(negedge wr_clk);
  endtask

  task automatic partial_reset();
    @(negedge wr_clk);
    prst_n   = 1'b0;
    mode_sel = 1'b0;
    repeat (4) @(negedge wr_clk);
    prst_n = 1'b1;
    repeat (2) @(negedge wr_clk);
  endtask

  initial begin
    repeat (50000) @(posedge wr_clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    // ---------------- standard mode ----------------
    master_reset(1'b0);
    check("R5 std rd_data", 32'(rd_data), 32'h0);
    check("R5 std empty", 32'(rd_flag), 32'h1);
    check("R5 std not full", 32'(wr_flag), 32'h0);

    oe_n = 1'b1;
    #1;
    check("R10 outputs released", 32'(rd_data === {DW{1'bz}}), 32'h1);
    oe_n = 1'b0;
    #1;
    check("R10 outputs driven", 32'(rd_data), 32'h0);

    // R1 R2 R9: walk the vector table
    for (int i = 0; i < 6; i++) begin
      if (VEC[i][37]) wr_word(VEC[i][36:19]);
      rd_step(1'b0, 1'b0);
      rd_step(1'b0, 1'b0);
      if (VEC[i][18]) rd_step(1'b1, 1'b0);
      check("R1/R2 vector rd_data", 32'(rd_data), 32'(VEC[i][17:0]));
    end
    check("R2 empty after walk", 32'(rd_flag), 32'h1);

    // R9: fill to the top, then one extra write
    for (int i = 0; i < DEPTH; i++) wr_word(DW'(18'h100 + i));
    check("R2 full flag", 32'(wr_flag), 32'h1);
    wr_word(18'h3FFFF);
    check("R9 still full", 32'(wr_flag), 32'h1);
    rd_step(1'b0, 1'b0);
    rd_step(1'b0, 1'b0);
    for (int i = 0; i < DEPTH; i++) begin
      rd_step(1'b1, 1'b0);
      check("R9 order after overflow", 32'(rd_data), 32'(18'h100 + i));
    end
    check("R9 empty after drain", 32'(rd_flag), 32'h1);
    rd_step(1'b1, 1'b0);
    check("R9 read on empty ignored", 32'(rd_data), 32'(18'h100 + DEPTH - 1));

    // R11, R7, R8: synchroniser latency and rewind
    master_reset(1'b0);
    wr_word(18'h0A1);
    check("R11 empty after first edge", 32'(rd_flag), 32'h1);
    rd_step(1'b0, 1'b0);
    check("R11 data after second edge", 32'(rd_flag), 32'h0);
    check("R2 no word without read", 32'(rd_data), 32'h0);
    wr_word(18'h0B2);
    wr_word(18'h0C3);
    rd_step(1'b0, 1'b0);
    rd_step(1'b0, 1'b0);
    rd_step(1'b1, 1'b0);
    check("R1 first read", 32'(rd_data), 32'h0A1);
    rd_step(1'b1, 1'b0);
    check("R1 second read", 32'(rd_data), 32'h0B2);
    rd_step(1'b1, 1'b1);
    check("R8 read dropped on rewind", 32'(rd_data), 32'h0B2);
    check("R7 std flag shows empty", 32'(rd_flag), 32'h1);
    rd_step(1'b0, 1'b0);
    check("R7 std flag clears", 32'(rd_flag), 32'h0);
    rd_step(1'b1, 1'b0);
    check("R7 reread first", 32'(rd_data), 32'h0A1);
    rd_step(1'b1, 1'b0);
    check("R7 reread second", 32'(rd_data), 32'h0B2);
    rd_step(1'b1, 1'b0);
    check("R7 reread third", 32'(rd_data), 32'h0C3);
    check("R7 write pointer kept", 32'(rd_flag), 32'h1);

    // ---------------- fall-through mode ----------------
    master_reset(1'b1);
    check("R5 ft rd_data", 32'(rd_data), 32'h0);
    check("R4 ft not valid", 32'(rd_flag), 32'h0);
    check("R4 ft ready", 32'(wr_flag), 32'h1);
    wr_word(18'h1E1);
    rd_step(1'b0, 1'b0);
    check("R3 not yet at second edge", 32'(rd_flag), 32'h0);
    rd_step(1'b0, 1'b0);
    check("R3 valid at third edge", 32'(rd_flag), 32'h1);
    check("R3 word falls through", 32'(rd_data), 32'h1E1);
    wr_word(18'h1E2);
    rd_step(1'b0, 1'b0);
    rd_step(1'b0, 1'b0);
    rd_step(1'b0, 1'b0);
    check("R3 later word waits", 32'(rd_data), 32'h1E1);
    rd_step(1'b1, 1'b0);
    check("R3 read presents next", 32'(rd_data), 32'h1E2);
    check("R3 still valid", 32'(rd_flag), 32'h1);
    rd_step(1'b0, 1'b1);
    check("R7 ft valid drops", 32'(rd_flag), 32'h0);
    rd_step(1'b0, 1'b0);
    check("R7 ft valid returns", 32'(rd_flag), 32'h1);
    check("R7 ft first word again", 32'(rd_data), 32'h1E1);

    partial_reset();
    check("R6 rd_data cleared", 32'(rd_data), 32'h0);
    check("R6 no word", 32'(rd_flag), 32'h0);
    check("R6 mode kept", 32'(wr_flag), 32'h1);
    wr_word(18'h2F3);
    rd_step(1'b0, 1'b0);
    rd_step(1'b0, 1'b0);
    check("R6 fall-through kept", 32'(rd_data), 32'h2F3);
    check("R6 valid after refill", 32'(rd_flag), 32'h1);

    summary();
    $finish;
  end

endmodule